// File: doc/BRIEF.md
# Execute Packet Splitter

This block sits between an instruction fetch buffer and the issue stage of a wide-issue core that relies on static grouping. Instruction words arrive one at a time on a valid/ready stream. The block groups them into execute packets, which are sets of up to eight words that issue together in one cycle. The grouping comes only from a chaining flag in bit 0 of each word. When the flag is set, the word joins the packet of the word before it. When the flag is clear, the word opens a new packet.

A packet is complete only once the word that follows it is known. For that reason the block holds the packet it is currently building. It releases that packet when a word with a clear flag arrives, when a word marked as the end of the stream is accepted, or when an overlong chain forces the packet to close at eight words. Completed packets wait in a two-entry buffer. While the issue stage stalls, the packet at the head of that buffer stays on the output unchanged. A synchronous flush drops everything the block holds.

The assembler has three states:

- `ASM_IDLE` means no packet is open. Any accepted word opens one and moves the assembler to `ASM_FILL`. If that word carries the end marker, the assembler moves to `ASM_CLOSE` instead.
- `ASM_FILL` means a packet is open. A chained word is appended. A word with a clear flag, or a ninth chained word, pushes the open packet and starts a new one with itself. An end-marked word moves the assembler to `ASM_CLOSE`.
- `ASM_CLOSE` means the open packet must be pushed. The assembler pushes it as soon as the buffer has room, then returns to `ASM_IDLE`.

A flush takes any state back to `ASM_IDLE`.

Top module: `pkt_splitter`

## Requirements
- R1: After reset, `out_valid` and `ovf_err` are low and `in_ready` is high.
- R2: An accepted word with bit 0 set joins the open packet. An accepted word with bit 0 clear closes the open packet and begins a new packet with itself.
- R3: The first word accepted after reset, after a flush, or after an end-marked word begins a new packet, whatever the value of its bit 0.
- R4: Packets leave in arrival order. Within a packet, the k-th word goes to slot k, which is `out_words[32k+31:32k]`, with `out_slot_vld[k]` set. The valid bits of a presented packet are a contiguous run that starts at bit 0.
- R5: An open packet is not presented while no closing event has occurred. The closing events are a clear-flag word, an end marker, or an overflow.
- R6: A word accepted with `in_last` high is the final word of its packet. That packet is on the output by the second clock edge after acceptance, provided the buffer has room.
- R7: If a chained word arrives while the open packet already holds eight words, the eight-word packet is closed and the extra word begins a new packet. `ovf_err` is high for exactly the one cycle that follows that acceptance.
- R8: While `out_valid` is high and `out_ready` is low, the presented packet stays unchanged. At most two completed packets are held. `in_ready` is low while both buffer entries are full.
- R9: While `flush` is high, `in_ready` is low. After a flush cycle, `out_valid` is low and every held packet and partial word is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous discard of all held words and packets |
| in_valid | input | 1 | Input word is present |
| in_ready | output | 1 | Block accepts the input word this cycle |
| in_word | input | 32 | Instruction word; bit 0 is the chaining flag |
| in_last | input | 1 | Marks the word as the end of the stream |
| out_valid | output | 1 | A complete packet is presented |
| out_ready | input | 1 | Issue stage takes the presented packet |
| out_slot_vld | output | 8 | Per-slot valid bits |
| out_words | output | 256 | Eight 32-bit slots; slot 0 in the low bits |
| ovf_err | output | 1 | One-cycle pulse when a chain exceeds eight words |

## Verification
An assembler that is stuck in or missing from `ASM_CLOSE` shows up within two cycles of an end-marked word. In that case the packet never appears, or it appears with the wrong slots. A wrong slot count or a wrong chaining decision changes the valid-bit mask of the very next packet that leaves. A buffer pointer or count error shows up as a repeated, lost or reordered packet once the issue stage stalls and resumes. It also shows up as `in_ready` staying high while two packets are pending. A flush that leaves stale state shows up as an extra packet, or a wrongly merged packet, on the first stream after the flush.

// File: rtl/pkt_split_pkg.sv
package pkt_split_pkg;
    localparam int DEF_SLOTS  = 8;
    localparam int DEF_WORD_W = 32;
    localparam int DEF_DEPTH  = 2;

    typedef enum logic [1:0] {
        ASM_IDLE  = 2'd0,
        ASM_FILL  = 2'd1,
        ASM_CLOSE = 2'd2
    } asm_state_e;
endpackage

// File: rtl/pkt_assembler.sv
module pkt_assembler
    import pkt_split_pkg::*;
#(
    parameter int SLOTS  = DEF_SLOTS,
    parameter int WORD_W = DEF_WORD_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush,
    input  logic                    in_valid,
    input  logic [WORD_W-1:0]       in_word,
    input  logic                    in_last,
    output logic                    in_ready,
    input  logic                    fifo_full,
    output logic                    push,
    output logic [SLOTS-1:0]        push_vld,
    output logic [SLOTS*WORD_W-1:0] push_words,
    output logic                    ovf_err
);
    localparam int CNT_W = $clog2(SLOTS + 1);
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(SLOTS);
    localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

    asm_state_e                     state_q, state_d;
    logic [SLOTS-1:0][WORD_W-1:0]   words_q, words_d;
    logic [SLOTS-1:0]               vld_q, vld_d;
    logic [CNT_W-1:0]               cnt_q, cnt_d;
    logic                           err_q, err_d;
    logic                           accept;
    logic                           chained;

    assign chained = in_word[0];
    assign accept  = in_valid && in_ready;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ASM_IDLE;
            words_q <= '0;
            vld_q   <= '0;
            cnt_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            words_q <= words_d;
            vld_q   <= vld_d;
            cnt_q   <= cnt_d;
            err_q   <= err_d;
        end
    end

    // Next-state and packet building
    always_comb begin
        state_d = state_q;
        words_d = words_q;
        vld_d   = vld_q;
        cnt_d   = cnt_q;
        err_d   = 1'b0;
        push    = 1'b0;
        unique case (state_q)
            ASM_IDLE: begin
                if (accept) begin
                    words_d    = '0;
                    vld_d      = '0;
                    words_d[0] = in_word;
                    vld_d[0]   = 1'b1;
                    cnt_d      = ONE_CNT;
                    state_d    = in_last ? ASM_CLOSE : ASM_FILL;
                end
            end
            ASM_FILL: begin
                if (accept) begin
                    if (chained && (cnt_q != FULL_CNT)) begin
                        words_d[cnt_q[IDX_W-1:0]] = in_word;
                        vld_d[cnt_q[IDX_W-1:0]]   = 1'b1;
                        cnt_d                     = cnt_q + ONE_CNT;
                    end else begin
                        push       = 1'b1;
                        err_d      = chained;
                        words_d    = '0;
                        vld_d      = '0;
                        words_d[0] = in_word;
                        vld_d[0]   = 1'b1;
                        cnt_d      = ONE_CNT;
                    end
                    state_d = in_last ? ASM_CLOSE : ASM_FILL;
                end
            end
            ASM_CLOSE: begin
                if (!fifo_full) begin
                    push    = 1'b1;
                    vld_d   = '0;
                    cnt_d   = '0;
                    state_d = ASM_IDLE;
                end
            end
            default: state_d = ASM_IDLE;
        endcase
        if (flush) begin
            push    = 1'b0;
            err_d   = 1'b0;
            vld_d   = '0;
            cnt_d   = '0;
            state_d = ASM_IDLE;
        end
    end

    // Outputs
    always_comb begin
        in_ready   = !flush && (state_q != ASM_CLOSE) && !fifo_full;
        push_vld   = vld_q;
        push_words = words_q;
        ovf_err    = err_q;
    end
endmodule

// File: rtl/pkt_fifo.sv
module pkt_fifo
    import pkt_split_pkg::*;
#(
    parameter int SLOTS  = DEF_SLOTS,
    parameter int WORD_W = DEF_WORD_W,
    parameter int DEPTH  = DEF_DEPTH
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush,
    input  logic                    push,
    input  logic [SLOTS-1:0]        push_vld,
    input  logic [SLOTS*WORD_W-1:0] push_words,
    output logic                    full,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [SLOTS-1:0]        out_vld,
    output logic [SLOTS*WORD_W-1:0] out_words
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [SLOTS-1:0]        vld_mem  [DEPTH];
    logic [SLOTS*WORD_W-1:0] word_mem [DEPTH];
    logic [PTR_W-1:0]        wr_ptr, rd_ptr;
    logic [CNT_W-1:0]        count;
    logic                    do_push, do_pop;

    assign full      = (count == MAX_CNT);
    assign out_valid = (count != '0);
    assign do_push   = push && !full;
    assign do_pop    = out_valid && out_ready;
    assign out_vld   = vld_mem[rd_ptr];
    assign out_words = word_mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push && !flush) begin
            vld_mem[wr_ptr]  <= push_vld;
            word_mem[wr_ptr] <= push_words;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + PTR_W'(1);
            if (do_pop)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + PTR_W'(1);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/pkt_splitter.sv
module pkt_splitter
    import pkt_split_pkg::*;
#(
    parameter int SLOTS  = DEF_SLOTS,
    parameter int WORD_W = DEF_WORD_W,
    parameter int DEPTH  = DEF_DEPTH
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [WORD_W-1:0]       in_word,
    input  logic                    in_last,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [SLOTS-1:0]        out_slot_vld,
    output logic [SLOTS*WORD_W-1:0] out_words,
    output logic                    ovf_err
);
    logic                    fifo_full;
    logic                    push;
    logic [SLOTS-1:0]        push_vld;
    logic [SLOTS*WORD_W-1:0] push_words;

    pkt_assembler #(.SLOTS(SLOTS), .WORD_W(WORD_W)) u_asm (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .in_valid   (in_valid),
        .in_word    (in_word),
        .in_last    (in_last),
        .in_ready   (in_ready),
        .fifo_full  (fifo_full),
        .push       (push),
        .push_vld   (push_vld),
        .push_words (push_words),
        .ovf_err    (ovf_err)
    );

    pkt_fifo #(.SLOTS(SLOTS), .WORD_W(WORD_W), .DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .push       (push),
        .push_vld   (push_vld),
        .push_words (push_words),
        .full       (fifo_full),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_vld    (out_slot_vld),
        .out_words  (out_words)
    );
endmodule

// File: rtl/pkt_splitter_chk.sv
module pkt_splitter_chk #(
    parameter int SLOTS  = 8,
    parameter int WORD_W = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    flush,
    input logic                    in_ready,
    input logic                    out_valid,
    input logic                    out_ready,
    input logic [SLOTS-1:0]        out_slot_vld,
    input logic [SLOTS*WORD_W-1:0] out_words,
    input logic                    ovf_err
);
    p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !flush) |=>
            (out_valid && $stable(out_slot_vld) && $stable(out_words)));

    p_slots_packed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_slot_vld[0] &&
            ((out_slot_vld & (out_slot_vld + SLOTS'(1))) == '0)));

    p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !out_valid);

    p_flush_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !in_ready);

    p_err_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |=> !ovf_err);
endmodule

bind pkt_splitter pkt_splitter_chk #(.SLOTS(SLOTS), .WORD_W(WORD_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush        (flush),
    .in_ready     (in_ready),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_slot_vld (out_slot_vld),
    .out_words    (out_words),
    .ovf_err      (ovf_err)
);

// File: tb/pkt_splitter_tb.sv
`timescale 1ns/1ps
module pkt_splitter_tb;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         flush;
    logic         in_valid;
    logic         in_ready;
    logic [31:0]  in_word;
    logic         in_last;
    logic         out_valid;
    logic         out_ready;
    logic [7:0]   out_slot_vld;
    logic [255:0] out_words;
    logic         ovf_err;

    always #4 clk = ~clk;

    pkt_splitter u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_slot_vld(out_slot_vld), .out_words(out_words), .ovf_err(ovf_err)
    );

    // {last, word}; bit 0 of the word is the chaining flag
    localparam logic [32:0] VEC [12] = '{
        {1'b0, 32'h1001_0001}, {1'b0, 32'h1002_0001}, {1'b0, 32'h1003_0000},
        {1'b0, 32'h1004_0000}, {1'b0, 32'h1005_0001}, {1'b0, 32'h1006_0001},
        {1'b0, 32'h1007_0001}, {1'b0, 32'h1008_0000}, {1'b1, 32'h1009_0001},
        {1'b0, 32'h100A_0001}, {1'b0, 32'h100B_0000}, {1'b1, 32'h100C_0001}
    };

    integer tests = 0, fails = 0, err_cnt = 0;
    integer sn = 0, exp_n = 0, got_n = 0;
    logic [31:0] sw [32];
    logic        sl [32];
    logic [31:0] exp_w [16][8];
    logic [7:0]  exp_v [16];
    logic [31:0] got_w [16][8];
    logic [7:0]  got_v [16];
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Monitor: samples away from both edges
    always @(negedge clk) begin
        #2;
        if (rst_n && ovf_err) err_cnt++;
        if (rst_n && out_valid && out_ready && got_n < 16) begin
            got_v[got_n] = out_slot_vld;
            for (int s = 0; s < 8; s++) got_w[got_n][s] = out_words[s*32 +: 32];
            got_n++;
        end
    end

    task automatic add(input logic [31:0] w, input logic l);
        sw[sn] = w; sl[sn] = l; sn++;
    endtask

    // Expected packets from R2, R3, R6, R7
    task automatic build_exp();
        int cnt; bit fresh; bit open;
        cnt = 0; fresh = 1; open = 0; exp_n = 0;
        for (int i = 0; i < sn; i++) begin
            if (!fresh && (!sw[i][0] || cnt == 8)) begin
                exp_n++; cnt = 0; open = 0;
            end
            if (!open) begin
                exp_v[exp_n] = '0;
                for (int s = 0; s < 8; s++) exp_w[exp_n][s] = '0;
                open = 1;
            end
            exp_w[exp_n][cnt] = sw[i];
            exp_v[exp_n][cnt] = 1'b1;
            cnt++;
            fresh = 0;
            if (sl[i]) begin
                exp_n++; cnt = 0; open = 0; fresh = 1;
            end
        end
    endtask

    // Called at a negedge; returns at a negedge with in_valid low
    task automatic send(input logic [31:0] w, input logic l);
        bit acc;
        in_valid = 1'b1; in_word = w; in_last = l;
        forever begin
            #1; acc = in_ready;
            @(posedge clk);
            @(negedge clk);
            if (acc) break;
        end
        in_valid = 1'b0;
    endtask

    task automatic clear_lists();
        sn = 0; got_n = 0; exp_n = 0;
    endtask

    task automatic compare(input string tag);
        bit ok;
        chk(got_n == exp_n, {tag, " packet count"}, got_n, exp_n);
        for (int p = 0; p < exp_n && p < got_n; p++) begin
            ok = (got_v[p] == exp_v[p]);
            for (int s = 0; s < 8; s++)
                if (exp_v[p][s] && got_w[p][s] != exp_w[p][s]) ok = 0;
            chk(ok, {tag, " packet content"}, {got_v[p], 24'h0, got_w[p][0]}, {exp_v[p], 24'h0, exp_w[p][0]});
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; flush = 1'b0; in_valid = 1'b0; in_word = '0; in_last = 1'b0; out_ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(!out_valid, "R1 out_valid after reset", out_valid, 0);
        chk(in_ready,   "R1 in_ready after reset", in_ready, 1);
        chk(!ovf_err,   "R1 ovf_err after reset", ovf_err, 0);
        @(negedge clk);

        // R2 R3 R4 R6: table-driven stream
        clear_lists(); err_cnt = 0;
        for (int i = 0; i < 12; i++) add(VEC[i][31:0], VEC[i][32]);
        build_exp();
        for (int i = 0; i < sn; i++) send(sw[i], sl[i]);
        repeat (8) @(negedge clk);
        compare("R2 R3 R4 table stream");
        chk(err_cnt == 0, "R7 no overflow pulse in table stream", err_cnt, 0);

        // R7 overflow at nine chained words
        clear_lists(); err_cnt = 0;
        for (int i = 1; i <= 9; i++) add(32'h2000_0001 | (i << 8), 1'b0);
        add(32'h2000_0A00, 1'b1);
        build_exp();
        for (int i = 0; i < 9; i++) send(sw[i], sl[i]);
        #1;
        chk(ovf_err, "R7 pulse in cycle after ninth word", ovf_err, 1);
        send(sw[9], sl[9]);
        repeat (8) @(negedge clk);
        compare("R7 overflow");
        chk(err_cnt == 1, "R7 single error pulse", err_cnt, 1);

        // R8 backpressure and buffer limit
        clear_lists(); out_ready = 1'b0;
        add(32'h3001_0000, 0); add(32'h3002_0001, 0); add(32'h3003_0000, 0);
        add(32'h3004_0000, 0); add(32'h3005_0000, 0); add(32'h3006_0001, 1);
        build_exp();
        for (int i = 0; i < 4; i++) send(sw[i], sl[i]);
        in_valid = 1'b1; in_word = sw[4]; in_last = 1'b0;
        for (int k = 0; k < 4; k++) begin
            #1;
            chk(!in_ready, "R8 in_ready low with two packets held", in_ready, 0);
            chk(out_valid && out_slot_vld == 8'h03 && out_words[31:0] == 32'h3001_0000,
                "R8 head held stable", {out_slot_vld, out_words[31:0]}, {8'h03, 32'h3001_0000});
            @(negedge clk);
        end
        out_ready = 1'b1;
        send(sw[4], sl[4]);
        send(sw[5], sl[5]);
        repeat (8) @(negedge clk);
        compare("R8 backpressure order");

        // R9 flush
        clear_lists(); out_ready = 1'b0;
        send(32'h4001_0000, 0); send(32'h4002_0000, 0); send(32'h4003_0001, 0);
        #1;
        chk(out_valid, "R9 packet pending before flush", out_valid, 1);
        @(negedge clk); flush = 1'b1; #1;
        chk(!in_ready, "R9 in_ready low during flush", in_ready, 0);
        @(negedge clk); flush = 1'b0; #1;
        chk(!out_valid, "R9 no packet after flush", out_valid, 0);
        @(negedge clk);
        clear_lists(); out_ready = 1'b1;
        add(32'h4004_0001, 1);
        build_exp();
        send(sw[0], sl[0]);
        repeat (8) @(negedge clk);
        compare("R9 R3 stream after flush");

        // R5 open packet withheld
        clear_lists();
        add(32'h5001_0000, 0); add(32'h5002_0001, 0); add(32'h5003_0000, 1);
        build_exp();
        send(sw[0], sl[0]); send(sw[1], sl[1]);
        repeat (4) @(negedge clk);
        #1;
        chk(!out_valid && got_n == 0, "R5 open packet not presented", {out_valid, got_n[7:0]}, 0);
        @(negedge clk);
        send(sw[2], sl[2]);
        repeat (8) @(negedge clk);
        compare("R5 closing by clear flag");

        // R6 end-marker latency
        clear_lists(); out_ready = 1'b0;
        add(32'h6001_0000, 1);
        build_exp();
        send(sw[0], sl[0]);
        #1;
        chk(!out_valid, "R6 not yet presented one edge after end word", out_valid, 0);
        @(negedge clk); #1;
        chk(out_valid, "R6 presented two edges after end word", out_valid, 1);
        @(negedge clk); out_ready = 1'b1;
        repeat (6) @(negedge clk);
        compare("R6 end marker");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule